// File: doc/BRIEF.md
# Temperature-Indexed Modulation Code Controller

This block produces the 8-bit code that sets a laser driver's modulation current. It holds a 45-entry table of byte codes, one for each band of die temperature. In table mode, every valid temperature sample is scaled onto the 45 bands by floor rounding, and the code stored for that band is presented at the output. In direct mode, software sets the output by writing a value register, and temperature samples are ignored.

A single register port gives software access to the table entries, the direct value and the mode bit. A mode change never pushes a fresh value to the output. Leaving table mode keeps the last table code until software writes a direct value. Returning to table mode keeps the current code until the next temperature sample arrives. Writes to table entries take effect only when a later sample selects them, so the output is a plain register that moves only on defined events.

Top module: `mod_lut_ctrl`

## Requirements
- R1: Addresses 0x00 to 0x2C of the register port are the 45 table entries (address = entry index), which can be written and read back. Address 0x30 is the direct value, and address 0x31 bit 0 is the mode bit (0 = table, 1 = direct). Every other address reads 0, and writes to it change nothing.
- R2: The table index is floor(temp_code × 45 / 255). A code of 255 gives 45, which is clamped to entry 44.
- R3: In table mode, the output takes the entry at the scaled index of temp_code_i on the clock edge where temp_vld_i is high. The output is visible one clock after the strobe and is held until the next update.
- R4: In direct mode, the output takes the written value on the clock edge of a write to address 0x30. Temperature strobes leave the output unchanged.
- R5: A switch from table mode to direct mode keeps the last table-derived output. A direct value written earlier is not applied.
- R6: A write to the direct value while in table mode is stored and can be read back, but it does not change the output.
- R7: After reset, the block is in table mode with an output of 0 and all table entries and the direct value at 0. The first strobe then loads the entry for the sampled temperature.
- R8: Rewriting any table entry, including the entry currently selected, leaves the output unchanged until the next temperature strobe.
- R9: A switch from direct mode to table mode holds the output until the next temperature strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write enable |
| reg_addr_i | input | 6 | Register address for reads and writes |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data, combinational from reg_addr_i |
| temp_code_i | input | 8 | Temperature ADC code |
| temp_vld_i | input | 1 | Temperature sample strobe |
| dac_code_o | output | 8 | Modulation DAC code |

## Verification
The assertions assume that a register write and a temperature strobe never fall in the same cycle as a mode-bit write. In that cycle, the hold properties would not know which event takes precedence. The directed tasks drive one event per cycle, on the falling clock edge, and separate each write from each strobe by at least one cycle. Temperature codes stay within the 8-bit range, and the full-scale code 255 is applied on purpose to exercise the clamp.

// File: rtl/mod_lut_pkg.sv
package mod_lut_pkg;
  typedef enum logic {
    MODE_TABLE  = 1'b0,
    MODE_DIRECT = 1'b1
  } lut_mode_e;
endpackage

// File: rtl/temp_index_scale.sv
module temp_index_scale #(
  parameter int TEMP_W = 8,
  parameter int DEPTH  = 45,
  localparam int IDX_W  = $clog2(DEPTH),
  localparam int PROD_W = TEMP_W + IDX_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              temp_vld_i,
  input  logic [TEMP_W-1:0] temp_code_i,
  output logic [IDX_W-1:0]  idx_o
);
  localparam int FULL = (1 << TEMP_W) - 1;

  logic [PROD_W-1:0] prod, quot;

  always_comb begin
    prod = PROD_W'(temp_code_i) * PROD_W'(DEPTH);
    quot = prod / PROD_W'(FULL);
    // full-scale code lands one past the last entry
    if (quot > PROD_W'(DEPTH - 1)) idx_o = IDX_W'(DEPTH - 1);
    else                           idx_o = quot[IDX_W-1:0];
  end

  AST_IDX_CLAMP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (temp_vld_i && temp_code_i == TEMP_W'(FULL)) |-> idx_o == IDX_W'(DEPTH - 1)); // R2
  AST_IDX_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    temp_vld_i |-> idx_o < IDX_W'(DEPTH)); // R2
  AST_IDX_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (temp_vld_i && temp_code_i == '0) |-> idx_o == '0); // R2
endmodule

// File: rtl/lut_table.sv
module lut_table #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 45,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [IDX_W-1:0]  lk_idx_i,
  output logic [DATA_W-1:0] lk_data_o,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [DATA_W-1:0] rd_data_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we_i && (waddr_i < IDX_W'(DEPTH))) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  always_comb begin
    lk_data_o = '0;
    rd_data_o = '0;
    if (lk_idx_i < IDX_W'(DEPTH)) lk_data_o = mem_q[lk_idx_i];
    if (rd_idx_i < IDX_W'(DEPTH)) rd_data_o = mem_q[rd_idx_i];
  end

  AST_TBL_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && waddr_i < IDX_W'(DEPTH)) |=> mem_q[$past(waddr_i)] == $past(wdata_i)); // R1
endmodule

// File: rtl/mod_code_sel.sv
module mod_code_sel
  import mod_lut_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  lut_mode_e         mode_i,
  input  logic              temp_vld_i,
  input  logic [DATA_W-1:0] lut_data_i,
  input  logic              dir_we_i,
  input  logic [DATA_W-1:0] dir_wdata_i,
  output logic [DATA_W-1:0] code_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_o <= '0;
    end else if (mode_i == MODE_DIRECT) begin
      if (dir_we_i) code_o <= dir_wdata_i;
    end else if (temp_vld_i) begin
      code_o <= lut_data_i;
    end
  end

  AST_TABLE_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_TABLE && temp_vld_i) |=> code_o == $past(lut_data_i)); // R3
  AST_DIRECT_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_DIRECT && dir_we_i) |=> code_o == $past(dir_wdata_i)); // R4
  AST_DIRECT_NO_TEMP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_DIRECT && !dir_we_i) |=> $stable(code_o)); // R4
  AST_TABLE_NO_DIR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_TABLE && !temp_vld_i) |=> $stable(code_o)); // R6
endmodule

// File: rtl/mod_lut_ctrl.sv
module mod_lut_ctrl
  import mod_lut_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int TEMP_W    = 8,
  parameter int DEPTH     = 45,
  parameter int ADDR_W    = 6,
  parameter int DIR_ADDR  = 48,
  parameter int MODE_ADDR = 49
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic [TEMP_W-1:0] temp_code_i,
  input  logic              temp_vld_i,
  output logic [DATA_W-1:0] dac_code_o
);
  localparam int IDX_W = $clog2(DEPTH);

  logic              tbl_hit, dir_hit, mode_hit;
  logic              tbl_we, dir_we, mode_we;
  logic [IDX_W-1:0]  lk_idx;
  logic [DATA_W-1:0] lk_data, tbl_rd;
  logic [DATA_W-1:0] dir_q;
  lut_mode_e         mode_q;

  assign tbl_hit  = reg_addr_i < ADDR_W'(DEPTH);
  assign dir_hit  = reg_addr_i == ADDR_W'(DIR_ADDR);
  assign mode_hit = reg_addr_i == ADDR_W'(MODE_ADDR);
  assign tbl_we   = reg_we_i && tbl_hit;
  assign dir_we   = reg_we_i && dir_hit;
  assign mode_we  = reg_we_i && mode_hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q  <= '0;
      mode_q <= MODE_TABLE;
    end else begin
      if (dir_we)  dir_q  <= reg_wdata_i;
      if (mode_we) mode_q <= lut_mode_e'(reg_wdata_i[0]);
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    if (tbl_hit)       reg_rdata_o = tbl_rd;
    else if (dir_hit)  reg_rdata_o = dir_q;
    else if (mode_hit) reg_rdata_o = DATA_W'(mode_q);
  end

  temp_index_scale #(.TEMP_W(TEMP_W), .DEPTH(DEPTH)) u_scale (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .temp_vld_i (temp_vld_i),
    .temp_code_i(temp_code_i),
    .idx_o      (lk_idx)
  );

  lut_table #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_table (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (tbl_we),
    .waddr_i  (reg_addr_i[IDX_W-1:0]),
    .wdata_i  (reg_wdata_i),
    .lk_idx_i (lk_idx),
    .lk_data_o(lk_data),
    .rd_idx_i (reg_addr_i[IDX_W-1:0]),
    .rd_data_o(tbl_rd)
  );

  mod_code_sel #(.DATA_W(DATA_W)) u_sel (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .mode_i     (mode_q),
    .temp_vld_i (temp_vld_i),
    .lut_data_i (lk_data),
    .dir_we_i   (dir_we),
    .dir_wdata_i(reg_wdata_i),
    .code_o     (dac_code_o)
  );

  AST_ENTER_DIRECT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_we && reg_wdata_i[0] && mode_q == MODE_TABLE && !temp_vld_i) |=> $stable(dac_code_o)); // R5
  AST_ENTER_TABLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_we && !reg_wdata_i[0] && mode_q == MODE_DIRECT) |=> $stable(dac_code_o)); // R9
  AST_TBL_WR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tbl_we && !temp_vld_i && !dir_we) |=> $stable(dac_code_o)); // R8
  AST_DIR_STORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dir_we |=> dir_q == $past(reg_wdata_i)); // R6
endmodule

// File: tb/sim_mod_lut_ctrl.sv
module sim_mod_lut_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       we = 1'b0;
  logic [5:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [7:0] tcode = '0;
  logic       tvld = 1'b0;
  logic [7:0] dac;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [7:0] model [45];

  always #10 clk = ~clk;

  mod_lut_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .temp_code_i(tcode),
    .temp_vld_i(tvld), .dac_code_o(dac)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic int exp_idx(input int c);
    int q = (c * 45) / 255;
    return (q > 44) ? 44 : q;
  endfunction

  task automatic wr(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic strobe(input logic [7:0] c);
    @(negedge clk); tvld = 1'b1; tcode = c;
    @(negedge clk); tvld = 1'b0;
  endtask

  task automatic t_reset;
    logic [7:0] v;
    chk("R7 dac after reset", dac, 8'h00);
    rd(6'h31, v); chk("R7 mode after reset", v, 8'h00);
    rd(6'h30, v); chk("R7 direct after reset", v, 8'h00);
    rd(6'h17, v); chk("R7 entry after reset", v, 8'h00);
  endtask

  task automatic t_fill;
    logic [7:0] v;
    for (int i = 0; i < 45; i++) begin
      model[i] = 8'(8'h20 + i * 5);
      wr(6'(i), model[i]);
    end
    rd(6'd0, v);  chk("R1 entry 0 readback", v, model[0]);
    rd(6'd44, v); chk("R1 entry 44 readback", v, model[44]);
    wr(6'd45, 8'hEE);
    rd(6'd45, v); chk("R1 unmapped read", v, 8'h00);
    rd(6'd44, v); chk("R1 unmapped write no effect", v, model[44]);
    chk("R8 fill leaves dac", dac, 8'h00);
  endtask

  task automatic t_scale;
    int codes [8] = '{0, 5, 6, 56, 57, 128, 254, 255};
    for (int k = 0; k < 8; k++) begin
      strobe(8'(codes[k]));
      chk($sformatf("R2 R3 code %0d", codes[k]), dac, model[exp_idx(codes[k])]);
    end
    @(negedge clk); tcode = 8'd3;
    @(negedge clk);
    chk("R3 hold without strobe", dac, model[44]);
  endtask

  task automatic t_rewrite;
    strobe(8'd128);
    wr(6'd22, 8'hC3);
    chk("R8 rewrite current entry", dac, model[22]);
    model[22] = 8'hC3;
    strobe(8'd128);
    chk("R8 next strobe picks new entry", dac, 8'hC3);
  endtask

  task automatic t_modes;
    logic [7:0] v;
    wr(6'h30, 8'h77);
    chk("R6 direct write in table mode", dac, 8'hC3);
    rd(6'h30, v); chk("R6 direct readback", v, 8'h77);
    wr(6'h31, 8'h01);
    chk("R5 switch keeps table value", dac, 8'hC3);
    rd(6'h31, v); chk("R1 mode readback", v, 8'h01);
    strobe(8'd0);
    chk("R4 strobe ignored in direct", dac, 8'hC3);
    wr(6'h30, 8'h5A);
    chk("R4 direct write applies", dac, 8'h5A);
    wr(6'd0, 8'h99); model[0] = 8'h99;
    chk("R8 entry write in direct mode", dac, 8'h5A);
    wr(6'h31, 8'h00);
    chk("R9 switch back holds", dac, 8'h5A);
    strobe(8'd2);
    chk("R3 R9 strobe after return", dac, 8'h99);
  endtask

  task automatic t_reset_first;
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    chk("R7 dac after second reset", dac, 8'h00);
    wr(6'd10, 8'h3C);
    strobe(8'd57);
    chk("R7 first strobe loads entry", dac, 8'h3C);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_fill();
    t_scale();
    t_rewrite();
    t_modes();
    t_reset_first();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule